// File: doc/BRIEF.md
# Multi-domain reset mode sequencer

This block sits on the system side of a processor cluster and drives five separate active-low reset lines: system power-on, CPU, debug, debug-APB and coherency-port. A request port names one reset mode. The block lowers the set of lines that belongs to that mode and keeps them low for a minimum number of clock cycles. It then releases every line and pulses a one-cycle completion flag.

Two modes reset only one domain while the shared bus fabric stays live: the CPU-only resets (warm and power-up) and the coherency-port reset. These two modes are held back until status inputs show that the domain is quiet, so the fabric never loses an interface in the middle of a transaction. The requester sets a bypass flag when the fabric is being reset at the same time. The block also starts a power-on sequence by itself whenever its own reset is released.

Top module: `rst_mode_seq`

## Requirements
- R1: While `rst_n` is low, all five reset lines are low and `busy` is high. After `rst_n` rises, the lines stay low for `HOLD_CYCLES` rising edges. They are then released together and `done` pulses.
- R2: Mode code 1 (power-on) drives all five reset lines low together.
- R3: Mode code 2 (CPU warm) drives only `cpu_rst_n` low.
- R4: Mode code 3 (CPU power-up) drives `cpu_rst_n` and `dbg_rst_n` low. If `req_emu_wake` is set with the request, only `cpu_rst_n` goes low.
- R5: Mode code 4 (debug) drives `dbg_rst_n` and `dbgapb_rst_n` low and leaves the other three lines high.
- R6: Mode code 5 (coherency port) drives only `cp_rst_n` low.
- R7: A sequence keeps its lines low for exactly `HOLD_CYCLES` cycles (values below 4 are raised to 4). In the cycle after the last low cycle, all lines are high, `busy` is low and `done` is high for one cycle.
- R8: Modes 2 and 3 start only when `cpu_no_traffic` is high and at least one of `cpu_wfe_stopped` or `cpu_wfi_stopped` is high, unless `req_with_bus` was set with the request. While the block waits, all lines stay high and `busy` is high.
- R9: Mode 5 starts only when both `cp_idle` and `cp_no_new_txn` are high, unless `req_with_bus` was set with the request. While the block waits, all lines stay high and `busy` is high.
- R10: A request is taken only when `busy` is low. A request presented while `busy` is high is dropped and has no effect on any line.
- R11: Mode codes 6 and 7 are undefined. They leave every line high, set `mode_err` and pulse `done` in the cycle after the request. The next accepted defined request clears `mode_err`.
- R12: Mode code 0 (normal) drives no line low and pulses `done` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer; release starts a power-on sequence |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_mode | input | 3 | Requested mode code (0 normal, 1 power-on, 2 CPU warm, 3 CPU power-up, 4 debug, 5 coherency port) |
| req_emu_wake | input | 1 | With mode 3: wake from an emulated low-power state, so debug stays alive |
| req_with_bus | input | 1 | The bus fabric is reset together with the domain; skip the quiescence wait |
| cpu_wfe_stopped | input | 1 | CPU pipeline stopped in wait-for-event |
| cpu_wfi_stopped | input | 1 | CPU pipeline stopped in wait-for-interrupt |
| cpu_no_traffic | input | 1 | No transactions to the CPU are outstanding and none can be issued |
| cp_idle | input | 1 | Coherency port reports idle |
| cp_no_new_txn | input | 1 | System can issue no new transactions to the coherency port |
| por_rst_n | output | 1 | System power-on reset, active low |
| cpu_rst_n | output | 1 | CPU reset, active low |
| dbg_rst_n | output | 1 | Debug logic reset, active low |
| dbgapb_rst_n | output | 1 | Debug-APB reset, active low |
| cp_rst_n | output | 1 | Coherency-port reset, active low |
| busy | output | 1 | Sequence waiting or holding |
| done | output | 1 | One-cycle pulse when a request completes |
| mode_err | output | 1 | Last accepted request named an undefined mode |

## Verification
The assertions check these properties on every cycle:
- every release comes after a low run of at least the hold length;
- a falling CPU-only or coherency-port-only line coincides with a quiet domain or a bypass;
- a low power-on line means every line is low, and a low debug-APB line means the debug line is low;
- `done` never overlaps `busy`;
- `mode_err` coincides with all lines high.

Only the bench's scenarios can show that each mode code produces exactly its own pattern for exactly the hold length. The same holds for the blocked cases: the effect of each quiescence input combination, that a request is dropped while busy, and that the error flag clears on the next defined request.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_POR    = 3'd1;
  localparam logic [2:0] MODE_WARM   = 3'd2;
  localparam logic [2:0] MODE_PWRUP  = 3'd3;
  localparam logic [2:0] MODE_DBG    = 3'd4;
  localparam logic [2:0] MODE_COHP   = 3'd5;

  // Asserted-high view of the reset lines; bit 4 is the power-on line.
  typedef struct packed {
    logic por;
    logic cpu;
    logic dbg;
    logic dbgapb;
    logic cohp;
  } rst_lines_t;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_CPU  = 2'd1,
    GATE_COHP = 2'd2
  } gate_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_t;

  function automatic int unsigned eff_hold(input int unsigned h);
    return (h < 4) ? 4 : h;
  endfunction

  function automatic logic mode_defined(input logic [2:0] m);
    return (m <= MODE_COHP);
  endfunction

  function automatic rst_lines_t mode_pattern(input logic [2:0] m, input logic emu);
    rst_lines_t p;
    p = '0;
    case (m)
      MODE_POR:   p = '1;
      MODE_WARM:  p.cpu = 1'b1;
      MODE_PWRUP: begin
        p.cpu = 1'b1;
        p.dbg = !emu;
      end
      MODE_DBG:   begin
        p.dbg    = 1'b1;
        p.dbgapb = 1'b1;
      end
      MODE_COHP:  p.cohp = 1'b1;
      default:    p = '0;
    endcase
    return p;
  endfunction

  function automatic gate_kind_t mode_gate(input logic [2:0] m);
    case (m)
      MODE_WARM, MODE_PWRUP: return GATE_CPU;
      MODE_COHP:             return GATE_COHP;
      default:               return GATE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rst_mode_decode.sv
module rst_mode_decode
  import rst_seq_pkg::*;
(
  input  logic [2:0]  mode,
  input  logic        emu_wake,
  output rst_lines_t  pattern,
  output gate_kind_t  gate,
  output logic        defined,
  output logic        is_normal
);

  always_comb begin
    pattern   = mode_pattern(mode, emu_wake);
    gate      = mode_gate(mode);
    defined   = mode_defined(mode);
    is_normal = (mode == MODE_NORMAL);
  end

endmodule

// File: rtl/rst_quiesce_gate.sv
module rst_quiesce_gate
  import rst_seq_pkg::*;
(
  input  gate_kind_t gate,
  input  logic       bypass,
  input  logic       cpu_wfe_stopped,
  input  logic       cpu_wfi_stopped,
  input  logic       cpu_no_traffic,
  input  logic       cp_idle,
  input  logic       cp_no_new_txn,
  output logic       ok
);

  logic cpu_quiet;
  logic cp_quiet;

  always_comb begin
    cpu_quiet = (cpu_wfe_stopped || cpu_wfi_stopped) && cpu_no_traffic;
    cp_quiet  = cp_idle && cp_no_new_txn;
    case (gate)
      GATE_CPU:  ok = bypass || cpu_quiet;
      GATE_COHP: ok = bypass || cp_quiet;
      default:   ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);

  localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (run && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rst_mode_seq.sv
module rst_mode_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       req_emu_wake,
  input  logic       req_with_bus,
  input  logic       cpu_wfe_stopped,
  input  logic       cpu_wfi_stopped,
  input  logic       cpu_no_traffic,
  input  logic       cp_idle,
  input  logic       cp_no_new_txn,
  output logic       por_rst_n,
  output logic       cpu_rst_n,
  output logic       dbg_rst_n,
  output logic       dbgapb_rst_n,
  output logic       cp_rst_n,
  output logic       busy,
  output logic       done,
  output logic       mode_err
);

  localparam int unsigned HOLD_EFF = eff_hold(HOLD_CYCLES);

  seq_state_t state_q;
  rst_lines_t lines_q;
  rst_lines_t pat_q;
  gate_kind_t gate_q;
  logic       bypass_q;
  logic       done_q;
  logic       err_q;

  rst_lines_t dec_pat;
  gate_kind_t dec_gate;
  logic       dec_defined;
  logic       dec_normal;

  // Named internal events, also observed by the checker.
  logic       accept;
  gate_kind_t gate_sel;
  logic       gate_bypass;
  logic       gate_ok;
  logic       start_hold;
  logic       hold_expire;

  rst_mode_decode u_dec (
    .mode      (req_mode),
    .emu_wake  (req_emu_wake),
    .pattern   (dec_pat),
    .gate      (dec_gate),
    .defined   (dec_defined),
    .is_normal (dec_normal)
  );

  assign accept      = req_valid && (state_q == ST_IDLE);
  assign gate_sel    = (state_q == ST_IDLE) ? dec_gate : gate_q;
  assign gate_bypass = (state_q == ST_IDLE) ? req_with_bus : bypass_q;

  rst_quiesce_gate u_gate (
    .gate            (gate_sel),
    .bypass          (gate_bypass),
    .cpu_wfe_stopped (cpu_wfe_stopped),
    .cpu_wfi_stopped (cpu_wfi_stopped),
    .cpu_no_traffic  (cpu_no_traffic),
    .cp_idle         (cp_idle),
    .cp_no_new_txn   (cp_no_new_txn),
    .ok              (gate_ok)
  );

  assign start_hold = gate_ok &&
                      ((accept && dec_defined && !dec_normal) || (state_q == ST_WAIT));

  rst_hold_timer #(.HOLD(HOLD_EFF)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_hold),
    .run    (state_q == ST_HOLD),
    .expire (hold_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HOLD;
      lines_q  <= '1;
      pat_q    <= '1;
      gate_q   <= GATE_NONE;
      bypass_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!dec_defined) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else if (dec_normal) begin
              err_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              err_q    <= 1'b0;
              pat_q    <= dec_pat;
              gate_q   <= dec_gate;
              bypass_q <= req_with_bus;
              if (start_hold) begin
                state_q <= ST_HOLD;
                lines_q <= dec_pat;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
        end
        ST_WAIT: begin
          if (start_hold) begin
            state_q <= ST_HOLD;
            lines_q <= pat_q;
          end
        end
        ST_HOLD: begin
          if (hold_expire) begin
            state_q <= ST_IDLE;
            lines_q <= '0;
            done_q  <= 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          lines_q <= '0;
        end
      endcase
    end
  end

  assign por_rst_n    = !lines_q.por;
  assign cpu_rst_n    = !lines_q.cpu;
  assign dbg_rst_n    = !lines_q.dbg;
  assign dbgapb_rst_n = !lines_q.dbgapb;
  assign cp_rst_n     = !lines_q.cohp;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign mode_err     = err_q;

endmodule

// File: rtl/rst_mode_seq_chk.sv
module rst_mode_seq_chk #(
  parameter int unsigned HOLD_EFF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic por_rst_n,
  input logic cpu_rst_n,
  input logic dbg_rst_n,
  input logic dbgapb_rst_n,
  input logic cp_rst_n,
  input logic busy,
  input logic done,
  input logic mode_err,
  input logic cpu_wfe_stopped,
  input logic cpu_wfi_stopped,
  input logic cpu_no_traffic,
  input logic cp_idle,
  input logic cp_no_new_txn,
  input logic gate_bypass
);

  logic        any_low;
  logic [15:0] low_cnt;

  assign any_low = !(por_rst_n && cpu_rst_n && dbg_rst_n && dbgapb_rst_n && cp_rst_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!any_low) begin
      low_cnt <= '0;
    end else if (low_cnt != 16'hFFFF) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assert_hold_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(any_low) && !any_low) |-> ($past(low_cnt) >= 16'(HOLD_EFF - 1)));

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_release_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_cpu_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_rst_n) && por_rst_n) |->
      $past(gate_bypass || ((cpu_wfe_stopped || cpu_wfi_stopped) && cpu_no_traffic)));

  assert_cp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cp_rst_n) && por_rst_n) |-> $past(gate_bypass || (cp_idle && cp_no_new_txn)));

  assert_por_all_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !por_rst_n |-> !(cpu_rst_n || dbg_rst_n || dbgapb_rst_n || cp_rst_n));

  assert_dbgapb_with_dbg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dbgapb_rst_n |-> !dbg_rst_n);

  assert_err_lines_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !any_low);

endmodule

bind rst_mode_seq rst_mode_seq_chk #(.HOLD_EFF(HOLD_EFF)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .por_rst_n       (por_rst_n),
  .cpu_rst_n       (cpu_rst_n),
  .dbg_rst_n       (dbg_rst_n),
  .dbgapb_rst_n    (dbgapb_rst_n),
  .cp_rst_n        (cp_rst_n),
  .busy            (busy),
  .done            (done),
  .mode_err        (mode_err),
  .cpu_wfe_stopped (cpu_wfe_stopped),
  .cpu_wfi_stopped (cpu_wfi_stopped),
  .cpu_no_traffic  (cpu_no_traffic),
  .cp_idle         (cp_idle),
  .cp_no_new_txn   (cp_no_new_txn),
  .gate_bypass     (gate_bypass)
);

// File: tb/tb_rst_mode_seq.sv
`timescale 1ns/1ps
module tb_rst_mode_seq;

  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic req_emu_wake = 1'b0;
  logic req_with_bus = 1'b0;
  logic cpu_wfe_stopped = 1'b1;
  logic cpu_wfi_stopped = 1'b1;
  logic cpu_no_traffic = 1'b1;
  logic cp_idle = 1'b1;
  logic cp_no_new_txn = 1'b1;
  logic por_rst_n, cpu_rst_n, dbg_rst_n, dbgapb_rst_n, cp_rst_n;
  logic busy, done, mode_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rst_mode_seq #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_emu_wake(req_emu_wake), .req_with_bus(req_with_bus),
    .cpu_wfe_stopped(cpu_wfe_stopped), .cpu_wfi_stopped(cpu_wfi_stopped),
    .cpu_no_traffic(cpu_no_traffic), .cp_idle(cp_idle), .cp_no_new_txn(cp_no_new_txn),
    .por_rst_n(por_rst_n), .cpu_rst_n(cpu_rst_n), .dbg_rst_n(dbg_rst_n),
    .dbgapb_rst_n(dbgapb_rst_n), .cp_rst_n(cp_rst_n),
    .busy(busy), .done(done), .mode_err(mode_err)
  );

  // Asserted lines as {por, cpu, dbg, dbgapb, cp}, 1 = held in reset.
  function automatic logic [4:0] lines_now();
    return {~por_rst_n, ~cpu_rst_n, ~dbg_rst_n, ~dbgapb_rst_n, ~cp_rst_n};
  endfunction

  function automatic logic [4:0] exp_pat(input int mode, input logic emu);
    case (mode)
      1: return 5'b11111;
      2: return 5'b01000;
      3: return emu ? 5'b01000 : 5'b01100;
      4: return 5'b00110;
      5: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic string tag_of(input int mode);
    case (mode)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      0: return "R12";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_quiet(input logic wfe, input logic wfi, input logic nt,
                           input logic idle, input logic nonew);
    cpu_wfe_stopped = wfe;
    cpu_wfi_stopped = wfi;
    cpu_no_traffic  = nt;
    cp_idle         = idle;
    cp_no_new_txn   = nonew;
  endtask

  // Presents a request for one cycle; returns at the negedge after the accepting edge.
  task automatic send_req(input int mode, input logic emu, input logic bus);
    @(negedge clk);
    req_valid    = 1'b1;
    req_mode     = 3'(mode);
    req_emu_wake = emu;
    req_with_bus = bus;
    @(negedge clk);
    req_valid    = 1'b0;
    req_emu_wake = 1'b0;
    req_with_bus = 1'b0;
  endtask

  // Called at the negedge after the edge that started the hold.
  task automatic expect_hold(input int mode, input logic emu, input string tag);
    for (int i = 0; i < HOLD; i++) begin
      check(tag, 32'(lines_now()), 32'(exp_pat(mode, emu)));
      check("R7 busy in hold", 32'(busy), 32'd1);
      @(negedge clk);
    end
    check("R7 released", 32'(lines_now()), 32'd0);
    check("R7 done pulse", 32'(done), 32'd1);
    check("R7 busy low", 32'(busy), 32'd0);
    @(negedge clk);
    check("R7 done single", 32'(done), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state and automatic power-on sequence.
    repeat (3) @(negedge clk);
    check("R1 lines in reset", 32'(lines_now()), 32'h1F);
    check("R1 busy in reset", 32'(busy), 32'd1);
    check("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < HOLD - 1; i++) begin
      @(negedge clk);
      check("R1 held after release", 32'(lines_now()), 32'h1F);
    end
    @(negedge clk);
    check("R1 released", 32'(lines_now()), 32'd0);
    check("R1 done", 32'(done), 32'd1);
    check("R1 busy", 32'(busy), 32'd0);
    @(negedge clk);

    // Sweep of every mode code, wake flavour and bypass flag with quiet domains.
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int b = 0; b < 2; b++) begin
          send_req(m, 1'(e), 1'(b));
          if (m >= 1 && m <= 5) begin
            check("R11 err cleared", 32'(mode_err), 32'd0);
            expect_hold(m, 1'(e), tag_of(m));
          end else begin
            check(tag_of(m), 32'(lines_now()), 32'd0);
            check(tag_of(m), 32'(done), 32'd1);
            check(tag_of(m), 32'(busy), 32'd0);
            check("R11 err flag", 32'(mode_err), (m >= 6) ? 32'd1 : 32'd0);
            @(negedge clk);
            check(tag_of(m), 32'(done), 32'd0);
          end
        end
      end
    end

    // R8: CPU quiescence for warm and power-up resets.
    for (int m = 2; m <= 3; m++) begin
      for (int q = 0; q < 8; q++) begin
        for (int b = 0; b < 2; b++) begin
          logic go;
          go = (b == 1) || ((q[2] || q[1]) && q[0]);
          set_quiet(q[2], q[1], q[0], 1'b0, 1'b0);
          send_req(m, 1'b0, 1'(b));
          if (go) begin
            expect_hold(m, 1'b0, "R8 quiet start");
          end else begin
            for (int k = 0; k < 3; k++) begin
              check("R8 waiting lines", 32'(lines_now()), 32'd0);
              check("R8 waiting busy", 32'(busy), 32'd1);
              @(negedge clk);
            end
            set_quiet(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
            @(negedge clk);
            expect_hold(m, 1'b0, "R8 late start");
          end
        end
      end
    end

    // R9: coherency-port quiescence.
    for (int q = 0; q < 4; q++) begin
      for (int b = 0; b < 2; b++) begin
        logic go;
        go = (b == 1) || (q[1] && q[0]);
        set_quiet(1'b0, 1'b0, 1'b0, q[1], q[0]);
        send_req(5, 1'b0, 1'(b));
        if (go) begin
          expect_hold(5, 1'b0, "R9 quiet start");
        end else begin
          for (int k = 0; k < 3; k++) begin
            check("R9 waiting lines", 32'(lines_now()), 32'd0);
            check("R9 waiting busy", 32'(busy), 32'd1);
            @(negedge clk);
          end
          set_quiet(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
          @(negedge clk);
          expect_hold(5, 1'b0, "R9 late start");
        end
      end
    end

    // R10: requests while busy are dropped (during wait and during hold).
    set_quiet(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    send_req(2, 1'b0, 1'b0);
    req_valid = 1'b1;
    req_mode  = 3'd1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 ignored in wait", 32'(lines_now()), 32'd0);
    check("R10 still busy", 32'(busy), 32'd1);
    set_quiet(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R10 original mode", 32'(lines_now()), 32'(exp_pat(2, 1'b0)));
    req_valid = 1'b1;
    req_mode  = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < HOLD - 1; i++) @(negedge clk);
    check("R10 release", 32'(done), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 hold request dropped", 32'(lines_now()), 32'd0);
      check("R10 no new sequence", 32'(busy), 32'd0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule